// File: doc/BRIEF.md
# Lockable Pin Configuration Register Bank

This block keeps one 32-bit configuration word for each pin of a 32-pin port and exposes it on a simple memory-mapped register bus. Software can program a pin by writing its own word, or it can program many pins at once through two write-only group registers. Each group register carries a 16-bit enable mask in its upper half and 16 bits of configuration data in its lower half. The data lands in the low half of every selected pin word.

A per-pin freeze bit protects the low half of a pin word, including the freeze bit itself, until the next reset. Group writes quietly skip frozen pins. The interrupt-mode nibble in the upper half stays writable whether or not the pin is frozen. The configuration fields are exported continuously as decoded per-pin vectors for the rest of the port logic: pull direction, pull enable, slow slew, passive filter, open drain, high drive, function select and interrupt mode.

Top module: `pin_cfg_bank`

## Requirements
- R1: A write to byte address 4·n (n = 0..31) updates pin word n, byte lane by byte lane under `wr_be`. Only the implemented bits hold a value: 0,1,2,4,5,6, 10:8, 15 and 19:16. Every other bit reads back as 0.
- R2: After reset every pin word reads 0x0000_0700, which means function select = 3'b111, interrupt mode = 0 and the freeze bit clear.
- R3: The exported fields follow the stored word. Bit 0 drives pull direction, bit 1 pull enable, bit 2 slow slew, bit 4 passive filter, bit 5 open drain and bit 6 high drive. Bits 10:8 are the function select, bit 15 is the freeze bit and bits 19:16 are the interrupt mode.
- R4: Once bit 15 of a pin word is 1, bits 15:0 of that word ignore every later single write and every group write, including writes that try to clear bit 15.
- R5: Bits 19:16 of a frozen pin word remain writable by single writes.
- R6: A write to 0x80 targets pins 0–15 and a write to 0x84 targets pins 16–31. Upper bit 16+k enables pin (group base + k). Every enabled pin that is not frozen takes data bits 15:0 into its bits 15:0, masked to the implemented bits.
- R7: A group write never changes bits 31:16 of any pin word, and it never changes any part of a frozen pin word.
- R8: A group write takes effect only when all four byte lanes are enabled (`wr_be` = 4'b1111).
- R9: Read data appears on `rd_data` in the cycle after `rd_en`. The group registers and every unmapped address read 0.
- R10: Reset clears the freeze bit, so a pin frozen before reset can be written again after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 8 | Byte address |
| wr_be | input | 4 | Byte-lane enables for writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| pull_sel | output | 32 | Per-pin pull direction (1 = up) |
| pull_en | output | 32 | Per-pin pull enable |
| slew_slow | output | 32 | Per-pin slow slew select |
| pfilt_en | output | 32 | Per-pin passive input filter enable |
| odrain_en | output | 32 | Per-pin open-drain enable |
| drive_hi | output | 32 | Per-pin high drive strength |
| func_sel | output | 96 | Per-pin 3-bit function select, pin n at [3n+2:3n] |
| irq_mode | output | 128 | Per-pin 4-bit interrupt mode, pin n at [4n+3:4n] |

## Verification
The assertions assume the bus issues one access per cycle and that `wr_en` and `rd_en` are never high together. A single write and a group write therefore never meet in the same cycle. The properties also take the byte address as word-aligned. The bench drives every access through one write task and one read task, which raise exactly one strobe for one cycle at a word-aligned address and lower it before the next access begins.

// File: rtl/pin_cfg_pkg.sv
package pin_cfg_pkg;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned GROUP_SZ = 16;

  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0700;
  localparam logic [CFG_W-1:0] LOW_IMPL  = 32'h0000_8777;
  localparam logic [CFG_W-1:0] HIGH_IMPL = 32'h000F_0000;

  localparam int unsigned B_PULL_SEL = 0;
  localparam int unsigned B_PULL_EN  = 1;
  localparam int unsigned B_SLEW     = 2;
  localparam int unsigned B_PFILT    = 4;
  localparam int unsigned B_ODRAIN   = 5;
  localparam int unsigned B_DRIVE    = 6;
  localparam int unsigned FSEL_LSB   = 8;
  localparam int unsigned FSEL_W     = 3;
  localparam int unsigned B_FREEZE   = 15;
  localparam int unsigned IMODE_LSB  = 16;
  localparam int unsigned IMODE_W    = 4;
endpackage

// File: rtl/pin_cfg_word.sv
module pin_cfg_word
  import pin_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [3:0]        sw_be,
  input  logic [CFG_W-1:0]  sw_data,
  input  logic              grp_we,
  input  logic [HALF_W-1:0] grp_data,
  output logic [CFG_W-1:0]  cfg_q
);
  logic             frozen;
  logic [CFG_W-1:0] lane_mask;
  logic [CFG_W-1:0] upd_mask;
  logic [CFG_W-1:0] cfg_d;

  assign frozen = cfg_q[B_FREEZE];

  always_comb begin
    lane_mask = {{8{sw_be[3]}}, {8{sw_be[2]}}, {8{sw_be[1]}}, {8{sw_be[0]}}};
    upd_mask  = '0;
    cfg_d     = cfg_q;
    if (sw_we) begin
      upd_mask = lane_mask & (HIGH_IMPL | (frozen ? '0 : LOW_IMPL));
      cfg_d    = (cfg_q & ~upd_mask) | (sw_data & upd_mask);
    end else if (grp_we && !frozen) begin
      cfg_d = (cfg_q & ~LOW_IMPL) | ({{(CFG_W-HALF_W){1'b0}}, grp_data} & LOW_IMPL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_RESET;
    else     cfg_q <= cfg_d;
  end
endmodule

// File: rtl/pin_cfg_group_dec.sv
module pin_cfg_group_dec
  import pin_cfg_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int ADDR_W     = 8,
  parameter int GROUP_BASE = 'h80
)(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        wr_be,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [NUM_PINS-1:0] grp_we,
  output logic [HALF_W-1:0] grp_data
);
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SZ;

  assign grp_data = wr_data[HALF_W-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = wr_en && (wr_be == 4'hF) && (addr == ADDR_W'(GROUP_BASE + 4 * g));
    for (genvar k = 0; k < GROUP_SZ; k++) begin : g_pin
      assign grp_we[g*GROUP_SZ + k] = hit & wr_data[HALF_W + k];
    end
  end
endmodule

// File: rtl/pin_cfg_rdport.sv
module pin_cfg_rdport
  import pin_cfg_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_PINS*CFG_W-1:0] cfg_flat,
  output logic [CFG_W-1:0]          rd_data
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [IDX_W-1:0] idx;
  logic             in_map;

  assign idx    = addr[IDX_W+1:2];
  assign in_map = int'(addr) < 4 * NUM_PINS;

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= in_map ? cfg_flat[idx*CFG_W +: CFG_W] : '0;
  end
endmodule

// File: rtl/pin_cfg_bank.sv
module pin_cfg_bank
  import pin_cfg_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int ADDR_W     = 8,
  parameter int GROUP_BASE = 'h80
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [3:0]                   wr_be,
  input  logic [CFG_W-1:0]             wr_data,
  output logic [CFG_W-1:0]             rd_data,
  output logic [NUM_PINS-1:0]          pull_sel,
  output logic [NUM_PINS-1:0]          pull_en,
  output logic [NUM_PINS-1:0]          slew_slow,
  output logic [NUM_PINS-1:0]          pfilt_en,
  output logic [NUM_PINS-1:0]          odrain_en,
  output logic [NUM_PINS-1:0]          drive_hi,
  output logic [NUM_PINS*FSEL_W-1:0]   func_sel,
  output logic [NUM_PINS*IMODE_W-1:0]  irq_mode
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [NUM_PINS*CFG_W-1:0] cfg_flat;
  logic [NUM_PINS-1:0]       grp_we;
  logic [HALF_W-1:0]         grp_data;
  logic [NUM_PINS-1:0]       freeze_vec;
  logic                      sw_hit;
  logic [IDX_W-1:0]          sw_idx;

  assign sw_hit = wr_en && (int'(addr) < 4 * NUM_PINS);
  assign sw_idx = addr[IDX_W+1:2];

  pin_cfg_group_dec #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .GROUP_BASE(GROUP_BASE)
  ) u_grp (
    .wr_en(wr_en), .addr(addr), .wr_be(wr_be), .wr_data(wr_data),
    .grp_we(grp_we), .grp_data(grp_data)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic [CFG_W-1:0] q;
    pin_cfg_word u_word (
      .clk(clk), .rst(rst),
      .sw_we(sw_hit && (sw_idx == IDX_W'(n))), .sw_be(wr_be), .sw_data(wr_data),
      .grp_we(grp_we[n]), .grp_data(grp_data),
      .cfg_q(q)
    );
    assign cfg_flat[n*CFG_W +: CFG_W]       = q;
    assign pull_sel[n]                      = q[B_PULL_SEL];
    assign pull_en[n]                       = q[B_PULL_EN];
    assign slew_slow[n]                     = q[B_SLEW];
    assign pfilt_en[n]                      = q[B_PFILT];
    assign odrain_en[n]                     = q[B_ODRAIN];
    assign drive_hi[n]                      = q[B_DRIVE];
    assign freeze_vec[n]                    = q[B_FREEZE];
    assign func_sel[n*FSEL_W +: FSEL_W]     = q[FSEL_LSB +: FSEL_W];
    assign irq_mode[n*IMODE_W +: IMODE_W]   = q[IMODE_LSB +: IMODE_W];
  end

  pin_cfg_rdport #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .cfg_flat(cfg_flat), .rd_data(rd_data)
  );
endmodule

// File: rtl/pin_cfg_bank_chk.sv
module pin_cfg_bank_chk
  import pin_cfg_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int ADDR_W     = 8,
  parameter int GROUP_BASE = 'h80
)(
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [CFG_W-1:0]            rd_data,
  input logic [NUM_PINS-1:0]         freeze_vec,
  input logic [NUM_PINS-1:0]         pull_sel,
  input logic [NUM_PINS*FSEL_W-1:0]  func_sel,
  input logic [NUM_PINS*IMODE_W-1:0] irq_mode
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    // R4: the freeze bit stays set until reset
    a_r4_freeze_sticky: assert property (@(posedge clk) disable iff (rst)
      freeze_vec[n] |=> freeze_vec[n]);
    // R4: low-half fields of a frozen pin do not move
    a_r4_low_frozen: assert property (@(posedge clk) disable iff (rst)
      freeze_vec[n] |=> ($stable(func_sel[n*FSEL_W +: FSEL_W]) && $stable(pull_sel[n])));
  end

  // R7: accesses at or above the group base never change the interrupt modes
  a_r7_group_keeps_high: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(addr) >= GROUP_BASE) |=> $stable(irq_mode));

  // R9: unmapped and group addresses read back zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(addr) >= 4 * NUM_PINS) |=> (rd_data == '0));

  // R1: without a write strobe nothing changes
  a_r1_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(func_sel) && $stable(irq_mode) && $stable(freeze_vec)));
endmodule

bind pin_cfg_bank pin_cfg_bank_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .GROUP_BASE(GROUP_BASE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rd_data(rd_data), .freeze_vec(freeze_vec), .pull_sel(pull_sel),
  .func_sel(func_sel), .irq_mode(irq_mode)
);

// File: tb/test_pin_cfg_bank.sv
`timescale 1ns/1ps
module test_pin_cfg_bank;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [3:0]    wr_be = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pull_sel, pull_en, slew_slow, pfilt_en, odrain_en, drive_hi;
  logic [NP*3-1:0] func_sel;
  logic [NP*4-1:0] irq_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_cfg_bank i_pin_cfg_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
    .pull_sel(pull_sel), .pull_en(pull_en), .slew_slow(slew_slow),
    .pfilt_en(pfilt_en), .odrain_en(odrain_en), .drive_hi(drive_hi),
    .func_sel(func_sel), .irq_mode(irq_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R2 pin0 reset", 8'h00, 32'h0000_0700);
    rd_chk("R2 pin31 reset", 8'h7C, 32'h0000_0700);
    chk("R2 func_sel all 7", {31'b0, func_sel == {NP{3'b111}}}, 32'd1);
    chk("R2 irq_mode zero", {31'b0, irq_mode == '0}, 32'd1);
  endtask

  task automatic t_single();
    bus_wr(8'h0C, 32'hFFFF_7FFF, 4'hF);
    rd_chk("R1 reserved bits zero", 8'h0C, 32'h000F_0777);
    bus_wr(8'h10, 32'hFFFF_FF12, 4'b0001);
    rd_chk("R1 byte lane 0 only", 8'h10, 32'h0000_0712);
  endtask

  task automatic t_fields();
    bus_wr(8'h14, 32'h0003_0265, 4'hF);
    @(negedge clk);
    chk("R3 field decode", {26'b0, pull_sel[5], pull_en[5], slew_slow[5],
        pfilt_en[5], odrain_en[5], drive_hi[5]}, 32'b101011);
    chk("R3 func_sel", {29'b0, func_sel[15 +: 3]}, 32'd2);
    chk("R3 irq_mode", {28'b0, irq_mode[20 +: 4]}, 32'd3);
  endtask

  task automatic t_freeze();
    bus_wr(8'h18, 32'h0000_8101, 4'hF);
    bus_wr(8'h18, 32'h0000_0000, 4'hF);
    rd_chk("R4 frozen ignores write", 8'h18, 32'h0000_8101);
    bus_wr(8'h18, 32'h000A_0000, 4'hF);
    rd_chk("R5 high half writable", 8'h18, 32'h000A_8101);
  endtask

  task automatic t_group();
    bus_wr(8'h04, 32'h0009_0700, 4'hF);
    bus_wr(8'h80, 32'h00C3_0044, 4'hF);
    rd_chk("R6 pin0 group data", 8'h00, 32'h0000_0044);
    rd_chk("R7 pin1 high kept", 8'h04, 32'h0009_0044);
    rd_chk("R6 pin7 group data", 8'h1C, 32'h0000_0044);
    rd_chk("R7 frozen pin6 skipped", 8'h18, 32'h000A_8101);
    rd_chk("R6 pin2 not enabled", 8'h08, 32'h0000_0700);
    bus_wr(8'h84, 32'h8001_0301, 4'hF);
    rd_chk("R6 pin16 high group", 8'h40, 32'h0000_0301);
    rd_chk("R6 pin31 high group", 8'h7C, 32'h0000_0301);
    rd_chk("R6 pin17 not enabled", 8'h44, 32'h0000_0700);
    chk("R6 pin16 func_sel", {29'b0, func_sel[48 +: 3]}, 32'd3);
  endtask

  task automatic t_partial();
    bus_wr(8'h80, 32'h0004_0000, 4'b0111);
    rd_chk("R8 partial group write ignored", 8'h08, 32'h0000_0700);
  endtask

  task automatic t_reads();
    rd_chk("R9 group low reads zero", 8'h80, 32'h0);
    rd_chk("R9 group high reads zero", 8'h84, 32'h0);
    rd_chk("R9 unmapped reads zero", 8'hC4, 32'h0);
  endtask

  task automatic t_rereset();
    do_reset();
    rd_chk("R10 pin6 reset", 8'h18, 32'h0000_0700);
    bus_wr(8'h18, 32'h0000_0000, 4'hF);
    rd_chk("R10 pin6 writable after reset", 8'h18, 32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_fields();
    t_freeze();
    t_group();
    t_partial();
    t_reads();
    t_rereset();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule